// File: doc/BRIEF.md
# Boost-Law Sine PWM Gate Generator

This block drives the four power switches of a differential boost inverter. The inverter is built from two legs, and each leg can boost or buck. The devices are grouped into two pairs. Pair A conducts while pair B is off, and then the roles swap, once in every carrier period.

A 32-bit phase accumulator tracks a 60 Hz output sine. For each output phase the block works out the instantaneous voltage gain M from the amplitude setting and the measured bus code. It then maps M to a duty ratio through the differential-boost law D = (M − 2 + √(M² + 4)) / (2M). It does not use a scaled sine as the duty. This keeps the stage's output sinusoidal even though its gain is nonlinear in the duty.

The duty values come from a table that is computed at elaboration. Only half a cycle is stored, because D(−M) = 1 − D(M). The duty is compared with a symmetric up/down triangle carrier. A gate sequencer inserts programmable dead time on every hand-over between the pairs.

The gate sequencer has four states:
- `ST_OFF`: all gates low.
- `ST_PAIR_A`: pair A on.
- `ST_PAIR_B`: pair B on.
- `ST_DEAD`: all gates low during a hand-over.

Its transitions are:
- *arm*: `ST_OFF`→`ST_DEAD`, when enable goes high.
- *drop A*: `ST_PAIR_A`→`ST_DEAD`, when the compare goes false.
- *drop B*: `ST_PAIR_B`→`ST_DEAD`, when the compare goes true.
- *settle*: `ST_DEAD`→`ST_PAIR_A` or `ST_PAIR_B`, chosen by the compare, when the dead timer expires.
- *halt*: any state→`ST_OFF`, when enable is low.

Top module: `dbi_spwm_gen`

## Requirements
- R1: While `enable` is low, `carrier_sync` is low, and all four gates are low from the cycle after `enable` was sampled low. Reset gives the same state.
- R2: While enabled, the carrier counts 0→`CAR_PEAK`→0. `carrier_sync` is high in the cycles where the count is 0. The first such cycle is the first enabled cycle, and every later one follows exactly 2·`CAR_PEAK` cycles after the previous one.
- R3: `gate_pa0` equals `gate_pa1` and `gate_pb0` equals `gate_pb1` at all times. Pairs A and B are never high together.
- R4: Every switch between pairs passes through E all-low cycles, where E = `dead_cycles`, or 1 when `dead_cycles` is 0.
- R5: The duty code d is the duty in carrier counts. It is loaded at a sync and used until the next sync. Take the window from the cycle after that sync to the next sync inclusive. In that window pair A is high 2·d − 1 − E cycles and the gates are all low 2·E cycles. For phase indices 1..127, d = round(`CAR_PEAK`·D(M)) with M = k·`GAIN_NUM`/`GAIN_DEN`·sin(2π·i/256).
- R6: The gain step k (0..15) is the number of integers j in 1..15 for which 2·j·`GAIN_NUM`·bus ≤ 2·`GAIN_DEN`·amp + `GAIN_NUM`·bus. This rounds halves upward and saturates at 15. A bus code of 0 gives 15.
- R7: When the phase index i is 0 or 128, or when k is 0, d is exactly `CAR_PEAK`/2.
- R8: For phase indices 128..255, d = `CAR_PEAK` minus the value for index i − 128.
- R9: d is clamped to [m, `CAR_PEAK` − m] with m = floor(`CAR_PEAK`·5/100).
- R10: The duty code changes only on the clock edge that ends a sync cycle. A change to `amp_code` or `bus_code` in mid-period has no effect until then.
- R11: The phase index i is bits 31:24 of the accumulator. The accumulator is 0 at the first sync after enable and adds `PHASE_STEP` at every sync, so sync n uses n·`PHASE_STEP`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run; low forces gates off and clears phase |
| bus_code | input | BUS_W | Measured DC bus voltage code |
| amp_code | input | AMP_W | Peak output amplitude, same scale as bus_code |
| dead_cycles | input | DEAD_W | Dead time in clock cycles (0 treated as 1) |
| gate_pa0 | output | 1 | Pair A, device 0 |
| gate_pa1 | output | 1 | Pair A, device 1 |
| gate_pb0 | output | 1 | Pair B, device 0 |
| gate_pb1 | output | 1 | Pair B, device 1 |
| carrier_sync | output | 1 | High at the carrier valley |

## Verification
The wrong-state cases show up at the ports as follows:
- A wrong table entry, wrong reflection or wrong gain step shows within one carrier period, as a pair-A on-time that differs from 2·d − 1 − E.
- A phase accumulator that slips shows as a sequence of on-times that drifts from n·`PHASE_STEP`.
- A sequencer stuck in, or skipping, `ST_DEAD` changes the count of all-low cycles in the very next window.
- A duty register that loads outside the valley breaks the on-time in the period where `amp_code` moves mid-period.

// File: rtl/dbi_spwm_pkg.sv
package dbi_spwm_pkg;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_PAIR_A,
        ST_PAIR_B,
        ST_DEAD
    } gate_st_e;

    localparam real TWO_PI = 6.283185307179586;

    // Duty in carrier counts for half-wave index h of 'steps' per cycle and gain step k.
    function automatic int law_duty(int h, int k, int steps, int peak, int num, int den);
        real m;
        real d;
        m = (real'(k) * real'(num) / real'(den)) * $sin(TWO_PI * real'(h) / real'(steps));
        if (m < 1.0e-9) begin
            return peak / 2;
        end
        d = (m - 2.0 + $sqrt(m * m + 4.0)) / (2.0 * m);
        return $rtoi(d * real'(peak) + 0.5);
    endfunction

endpackage

// File: rtl/dbi_spwm_carrier.sv
module dbi_spwm_carrier #(
    parameter int PEAK = 4630,
    parameter int CW   = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    output logic [CW-1:0] cnt,
    output logic          sync
);
    logic up;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            up  <= 1'b1;
        end else if (!en) begin
            cnt <= '0;
            up  <= 1'b1;
        end else if (up) begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(PEAK - 1)) up <= 1'b0;
        end else begin
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) up <= 1'b1;
        end
    end

    assign sync = en && (cnt == '0);
endmodule

// File: rtl/dbi_spwm_ref.sv
module dbi_spwm_ref #(
    parameter int          PEAK       = 4630,
    parameter int          CW         = 13,
    parameter int          BUS_W      = 12,
    parameter int          AMP_W      = 12,
    parameter int          GAIN_NUM   = 1,
    parameter int          GAIN_DEN   = 3,
    parameter logic [31:0] PHASE_STEP = 32'd11930,
    parameter int          PH_BITS    = 8,
    parameter int          RQ_BITS    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             sync,
    input  logic [BUS_W-1:0] bus,
    input  logic [AMP_W-1:0] amp,
    output logic [CW-1:0]    duty
);
    localparam int H_N   = 1 << (PH_BITS - 1);
    localparam int K_N   = 1 << RQ_BITS;
    localparam int ROM_N = H_N * K_N;
    localparam int HALF  = PEAK / 2;
    localparam int DMIN  = PEAK * 5 / 100;
    localparam int DMAX  = PEAK - DMIN;

    logic [CW-1:0]      rom [ROM_N];
    logic [31:0]        phase;
    logic [RQ_BITS-1:0] k_sel;
    logic [PH_BITS-1:0] idx;
    logic [CW-1:0]      raw, refl, clamped;

    for (genvar kk = 0; kk < K_N; kk++) begin : g_k
        for (genvar hh = 0; hh < H_N; hh++) begin : g_h
            localparam int VAL = dbi_spwm_pkg::law_duty(hh, kk, 2 * H_N, PEAK, GAIN_NUM, GAIN_DEN);
            assign rom[kk * H_N + hh] = CW'(VAL);
        end
    end

    // Rounded, saturating bus-to-amplitude gain step.
    always_comb begin
        k_sel = '0;
        for (int j = 1; j < K_N; j++) begin
            if (64'(j) * 64'(2 * GAIN_NUM) * 64'(bus) <=
                64'(2 * GAIN_DEN) * 64'(amp) + 64'(GAIN_NUM) * 64'(bus))
                k_sel = RQ_BITS'(j);
        end
    end

    assign idx  = phase[31 -: PH_BITS];
    assign raw  = rom[{k_sel, idx[PH_BITS-2:0]}];
    assign refl = idx[PH_BITS-1] ? (CW'(PEAK) - raw) : raw;

    always_comb begin
        clamped = refl;
        if (refl < CW'(DMIN)) clamped = CW'(DMIN);
        if (refl > CW'(DMAX)) clamped = CW'(DMAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
            duty  <= CW'(HALF);
        end else if (!en) begin
            phase <= '0;
            duty  <= CW'(HALF);
        end else if (sync) begin
            phase <= phase + PHASE_STEP;
            duty  <= clamped;
        end
    end
endmodule

// File: rtl/dbi_spwm_gatefsm.sv
module dbi_spwm_gatefsm #(
    parameter int CW  = 13,
    parameter int DTW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic [CW-1:0]  cnt,
    input  logic [CW-1:0]  duty,
    input  logic [DTW-1:0] dead,
    output logic           pair_a,
    output logic           pair_b
);
    import dbi_spwm_pkg::*;

    gate_st_e       st, nxt;
    logic [DTW-1:0] dt_cnt, dt_load;
    logic           want_a;

    assign want_a  = cnt < duty;
    assign dt_load = (dead == '0) ? '0 : dead - 1'b1;

    always_comb begin
        nxt = st;
        unique case (st)
            ST_OFF:    if (en) nxt = ST_DEAD;
            ST_PAIR_A: if (!want_a) nxt = ST_DEAD;
            ST_PAIR_B: if (want_a) nxt = ST_DEAD;
            ST_DEAD:   if (dt_cnt == '0) nxt = want_a ? ST_PAIR_A : ST_PAIR_B;
        endcase
        if (!en) nxt = ST_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_OFF;
            dt_cnt <= '0;
        end else begin
            st <= nxt;
            if (nxt == ST_DEAD && st != ST_DEAD) dt_cnt <= dt_load;
            else if (st == ST_DEAD && dt_cnt != '0) dt_cnt <= dt_cnt - 1'b1;
        end
    end

    always_comb begin
        pair_a = 1'b0;
        pair_b = 1'b0;
        unique case (st)
            ST_PAIR_A: pair_a = 1'b1;
            ST_PAIR_B: pair_b = 1'b1;
            ST_OFF, ST_DEAD: ;
        endcase
    end
endmodule

// File: rtl/dbi_spwm_gen.sv
module dbi_spwm_gen #(
    parameter int          CLK_HZ     = 200_000_000,
    parameter int          OUT_HZ     = 60,
    parameter int          CAR_PEAK   = 4630,
    parameter int          GAIN_NUM   = 1,
    parameter int          GAIN_DEN   = 3,
    parameter int          BUS_W      = 12,
    parameter int          AMP_W      = 12,
    parameter int          DEAD_W     = 8,
    parameter logic [31:0] PHASE_STEP = 32'((64'(OUT_HZ) << 32) * 64'(2 * CAR_PEAK) / 64'(CLK_HZ))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [BUS_W-1:0]  bus_code,
    input  logic [AMP_W-1:0]  amp_code,
    input  logic [DEAD_W-1:0] dead_cycles,
    output logic              gate_pa0,
    output logic              gate_pa1,
    output logic              gate_pb0,
    output logic              gate_pb1,
    output logic              carrier_sync
);
    localparam int CW = $clog2(CAR_PEAK + 1);

    logic [CW-1:0] car_cnt;
    logic [CW-1:0] duty_q;
    logic          pa, pb;

    dbi_spwm_carrier #(.PEAK(CAR_PEAK), .CW(CW)) u_car (
        .clk(clk), .rst_n(rst_n), .en(enable), .cnt(car_cnt), .sync(carrier_sync)
    );

    dbi_spwm_ref #(
        .PEAK(CAR_PEAK), .CW(CW), .BUS_W(BUS_W), .AMP_W(AMP_W),
        .GAIN_NUM(GAIN_NUM), .GAIN_DEN(GAIN_DEN), .PHASE_STEP(PHASE_STEP),
        .PH_BITS(8), .RQ_BITS(4)
    ) u_ref (
        .clk(clk), .rst_n(rst_n), .en(enable), .sync(carrier_sync),
        .bus(bus_code), .amp(amp_code), .duty(duty_q)
    );

    dbi_spwm_gatefsm #(.CW(CW), .DTW(DEAD_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(enable), .cnt(car_cnt), .duty(duty_q),
        .dead(dead_cycles), .pair_a(pa), .pair_b(pb)
    );

    assign gate_pa0 = pa;
    assign gate_pa1 = pa;
    assign gate_pb0 = pb;
    assign gate_pb1 = pb;
endmodule

// File: rtl/dbi_spwm_gen_chk.sv
module dbi_spwm_gen_chk #(
    parameter int PEAK = 4630,
    parameter int CW   = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          pa0,
    input logic          pa1,
    input logic          pb0,
    input logic          pb1,
    input logic          sync,
    input logic [CW-1:0] duty
);
    localparam int DMIN = PEAK * 5 / 100;
    localparam int DMAX = PEAK - DMIN;

    logic [CW+1:0] gap;
    logic          seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (!en) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (sync) begin
            gap  <= (CW+2)'(1);
            seen <= 1'b1;
        end else begin
            gap <= gap + 1'b1;
        end
    end

    AST_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!pa0 && !pa1 && !pb0 && !pb1)); // R1
    AST_SYNC_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sync && seen) |-> (gap == (CW+2)'(2 * PEAK))); // R2
    AST_SYNC_NOT_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sync) |-> (gap < (CW+2)'(2 * PEAK))); // R2
    AST_DEAD_BEFORE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pa0) || $rose(pb0)) |-> $past(!pa0 && !pb0)); // R4
    AST_DUTY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (duty >= CW'(DMIN)) && (duty <= CW'(DMAX))); // R9
    AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !$past(sync)) |-> $stable(duty)); // R10
endmodule

bind dbi_spwm_gen dbi_spwm_gen_chk #(.PEAK(CAR_PEAK), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(enable),
    .pa0(gate_pa0), .pa1(gate_pa1), .pb0(gate_pb0), .pb1(gate_pb1),
    .sync(carrier_sync), .duty(duty_q)
);

// File: tb/dbi_spwm_gen_tb.sv
`timescale 1ns/1ps
module dbi_spwm_gen_tb;
    localparam int  PEAK     = 100;
    localparam int  NUM      = 2;
    localparam int  DEN      = 1;
    localparam int  STEP_IDX = 3;
    localparam int  DMIN     = PEAK * 5 / 100;
    localparam int  DMAX     = PEAK - DMIN;
    localparam real TWO_PI   = 6.283185307179586;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [11:0] bus = '0;
    logic [11:0] amp = '0;
    logic [7:0]  dead = '0;
    logic        g_a0, g_a1, g_b0, g_b1, sync;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dbi_spwm_gen #(
        .CAR_PEAK(PEAK), .GAIN_NUM(NUM), .GAIN_DEN(DEN),
        .PHASE_STEP(32'(STEP_IDX) << 24)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(en), .bus_code(bus), .amp_code(amp),
        .dead_cycles(dead), .gate_pa0(g_a0), .gate_pa1(g_a1), .gate_pb0(g_b0),
        .gate_pb1(g_b1), .carrier_sync(sync)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_k(int a, int b);
        int k = 0;
        for (int j = 1; j < 16; j++)
            if (2 * j * NUM * b <= 2 * DEN * a + NUM * b) k = j;
        return k;
    endfunction

    function automatic int exp_raw(int p, int k);
        int  h = p % 128;
        int  r;
        real m, d;
        if (k == 0 || h == 0) begin
            r = PEAK / 2;
        end else begin
            m = (real'(k) * real'(NUM) / real'(DEN)) * $sin(TWO_PI * real'(h) / real'(256));
            d = (m - 2.0 + $sqrt(m * m + 4.0)) / (2.0 * m);
            r = $rtoi(d * real'(PEAK) + 0.5);
        end
        if (p >= 128) r = PEAK - r;
        return r;
    endfunction

    task automatic check_off(input string tag);
        @(negedge clk); #1;
        chk(!g_a0 && !g_a1 && !g_b0 && !g_b1 && !sync, tag,
            {g_a0, g_a1, g_b0, g_b1, sync}, 0);
    endtask

    // Enable, measure nper windows, disable.
    task automatic run(input int a, input int b, input int dt, input int nper,
                       input int alt_a, input string tag);
        int  dte, nsync, acnt, dcnt, bad, gap, kwin, pwin, raw, d, cur_a;
        bit  active;
        string t;
        dte = (dt == 0) ? 1 : dt;
        nsync = 0; active = 0; acnt = 0; dcnt = 0; bad = 0; gap = 0;
        kwin = 0; pwin = 0; cur_a = a;
        amp = 12'(a); bus = 12'(b); dead = 8'(dt);
        @(negedge clk);
        en = 1'b1;
        #1;
        chk(sync == 1'b1, "R2 first sync", sync, 1);
        while (nsync <= nper) begin
            if (active) begin
                acnt += int'(g_a0);
                dcnt += int'(!g_a0 && !g_b0);
                bad  += int'((g_a0 != g_a1) || (g_b0 != g_b1) || (g_a0 && g_b0));
                gap++;
            end
            if (sync) begin
                if (active && nsync > 1) begin
                    raw = exp_raw(pwin, kwin);
                    d = raw < DMIN ? DMIN : (raw > DMAX ? DMAX : raw);
                    if (kwin == 0 || pwin % 128 == 0) t = "R7";
                    else if (raw != d) t = "R9";
                    else if (pwin >= 128) t = "R8";
                    else t = "R5";
                    chk(acnt == 2 * d - 1 - dte,
                        $sformatf("%s/%s/R11 pair-A on-time p=%0d k=%0d", t, tag, pwin, kwin),
                        acnt, 2 * d - 1 - dte);
                    chk(dcnt == 2 * dte, "R4 dead cycles per window", dcnt, 2 * dte);
                    chk(bad == 0, "R3 pair consistency", bad, 0);
                    chk(gap == 2 * PEAK, "R2 sync spacing", gap, 2 * PEAK);
                end
                kwin = exp_k(cur_a, b);
                pwin = (nsync * STEP_IDX) % 256;
                acnt = 0; dcnt = 0; bad = 0; gap = 0;
                active = 1;
                nsync++;
            end
            if (alt_a != a && gap == PEAK) begin
                cur_a = (cur_a == a) ? alt_a : a; // R10 mid-period change
                amp = 12'(cur_a);
            end
            @(negedge clk); #1;
        end
        en = 1'b0;
        check_off("R1 gates after disable");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog actual=%0d expected=%0d", 190000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        #1;
        chk(!g_a0 && !g_b0 && !sync, "R1 reset state", {g_a0, g_b0, sync}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        amp = 12'd600; bus = 12'd100; dead = 8'd2;
        check_off("R1 idle while disabled");
        check_off("R1 idle while disabled");
        run(600, 100, 2, 256, 600, "R5");   // k=3, full phase sweep
        run(4000, 100, 3, 86, 4000, "R6");  // saturated k=15, clamping
        run(50, 0, 0, 10, 50, "R6");        // zero bus gives k=15, dead 0 acts as 1
        run(0, 100, 1, 10, 0, "R7");        // k=0 gives half duty
        run(250, 100, 2, 8, 250, "R6");     // 1.25 rounds to 1
        run(350, 100, 2, 8, 350, "R6");     // 1.75 rounds to 2
        run(300, 100, 2, 8, 300, "R6");     // 1.5 rounds up to 2
        run(600, 100, 2, 40, 1200, "R10");  // amp toggled mid-period
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule